// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches the already-synchronized levels of a bank of general-purpose pins and turns configured transitions or levels into interrupt events. Each pin has two configuration bits, a level/edge select and an invert bit, which together choose one of four trigger kinds: rising edge, falling edge, low level or high level. A detected event sets a sticky per-pin status bit. Software clears a status bit by writing a 1 to it.

A per-pin enable bitmap qualifies the status bits. The OR of all enabled, pending status bits drives one registered summary interrupt line. Status and enable are reached as 32-bit words, where pin p sits at bit p mod 32 of word p/32. A pin only produces events while it is owned by the host, selected for GPIO use, and has input sensing turned on.

Top module: `pin_event_irq`

## Requirements
- R1: With level_sel=0 and invert=0 (rising edge), a pin's status bit is set on the clock edge where its level is 1 and the level sampled one clock earlier was 0.
- R2: With level_sel=0 and invert=1 (falling edge), a pin's status bit is set on the clock edge where its level is 0 and the level sampled one clock earlier was 1.
- R3: With level_sel=1 and invert=0 (low level), a pin's status bit is set on every clock edge at which its level is 0.
- R4: With level_sel=1 and invert=1 (high level), a pin's status bit is set on every clock edge at which its level is 1.
- R5: A write with wr_target=0 to word w clears status bit b of that word when wr_data bit b is 1, and leaves it unchanged when that bit is 0. Status bits stay set until cleared.
- R6: When an event and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R7: A pin with sense_off=1, owned=0 or gpio_mode=0 never sets its status bit.
- R8: A write with wr_target=1 to word w loads enable bits for pins 32w..32w+31 from wr_data. rd_enable and rd_status return word rd_word, and bit positions with no pin read 0.
- R9: irq_out is registered. It is 1 one clock after any pin has both its status bit and its enable bit set, and 0 one clock after no such pin exists.
- R10: Reset clears status, enable and irq_out. A pin level already present during reset produces no edge event after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NUM_PINS | Synchronized pin input levels |
| level_sel | input | NUM_PINS | Per-pin trigger select: 0 edge, 1 level |
| invert | input | NUM_PINS | Per-pin polarity: 0 rising/low, 1 falling/high |
| sense_off | input | NUM_PINS | Per-pin input sensing disabled |
| owned | input | NUM_PINS | Per-pin host ownership, 0 means reserved |
| gpio_mode | input | NUM_PINS | Per-pin use field equals GPIO |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 1 | 0 status (write-1-to-clear), 1 enable |
| wr_word | input | WIDX_W | Word index of the write |
| wr_data | input | WORD_W | Write data |
| rd_word | input | WIDX_W | Word index of the read |
| rd_status | output | WORD_W | Status word selected by rd_word |
| rd_enable | output | WORD_W | Enable word selected by rd_word |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A wrong edge history or a misdecoded trigger kind shows up as a wrong status bit on rd_status one clock after the stimulating level change. A status or enable bit sitting in the wrong lane appears as a stray bit in the wrong word or as a missing summary interrupt. Any mismatch between pending enabled status and irq_out can be seen exactly one clock later, because the summary is a single register stage. A clear that wrongly overrides a persisting level event shows as a 0 where a 1 is required, in the same cycle the clear lands.

// File: rtl/pin_event_pkg.sv
// Shared definitions for the pin event detector.
// Assumes the trigger kind is formed as {level_sel, invert}.
package pin_event_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_kind_e;

    // Decide whether a pin's current and previous level form an event of kind k.
    function automatic logic event_hit(input trig_kind_e k, input logic now_lvl,
                                       input logic was_lvl);
        logic hit;
        case (k)
            TRIG_RISE: hit = now_lvl & ~was_lvl;
            TRIG_FALL: hit = ~now_lvl & was_lvl;
            TRIG_LOW:  hit = ~now_lvl;
            default:   hit = now_lvl;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pin_event_detect.sv
// Per-pin event detection.
// Keeps the previous sampled level of every pin and flags one-cycle events
// per the pin's trigger kind. Gated pins (not owned, not GPIO, sensing off)
// flag nothing. The history register follows the pin during reset too, so a
// level held through reset is not seen as an edge afterwards.
module pin_event_detect #(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] level_sel,
    input  logic [NUM_PINS-1:0] invert,
    input  logic [NUM_PINS-1:0] sense_off,
    input  logic [NUM_PINS-1:0] owned,
    input  logic [NUM_PINS-1:0] gpio_mode,
    output logic [NUM_PINS-1:0] event_vec
);
    import pin_event_pkg::*;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic prev_q;
        logic qual;

        // Track the level seen one clock earlier.
        always_ff @(posedge clk) begin
            prev_q <= pin_level[i];
        end

        // Only host-owned GPIO pins with sensing on may raise events.
        assign qual = owned[i] & gpio_mode[i] & ~sense_off[i];

        // Decode the trigger kind into an event for this cycle.
        assign event_vec[i] = qual & event_hit(trig_kind_e'({level_sel[i], invert[i]}),
                                               pin_level[i], prev_q);
    end

endmodule

// File: rtl/pin_status_bank.sv
// Sticky per-pin status bits.
// Set by events, cleared by a clear mask; an event outranks a clear on the
// same edge.
module pin_status_bank #(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] event_vec,
    input  logic [NUM_PINS-1:0] clr_vec,
    output logic [NUM_PINS-1:0] status_vec
);

    // Clear first, then merge new events so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_vec <= '0;
        else        status_vec <= (status_vec & ~clr_vec) | event_vec;
    end

endmodule

// File: rtl/pin_enable_bank.sv
// Per-pin interrupt enable bits, written one WORD_W-bit word at a time.
// A word index with no pins behind it writes nothing.
module pin_enable_bank #(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int WIDX_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WIDX_W-1:0]   wr_word,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] enable_vec
);
    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    logic [PAD_W-1:0] data_pad;
    logic [PAD_W-1:0] mask_pad;

    // Move the written word and its lane mask to the addressed position.
    always_comb begin
        data_pad = PAD_W'(wr_data) << (wr_word * WORD_W);
        mask_pad = PAD_W'({WORD_W{1'b1}}) << (wr_word * WORD_W);
    end

    // Replace only the addressed lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_vec <= '0;
        else if (wr_en)
            enable_vec <= (enable_vec & ~mask_pad[NUM_PINS-1:0])
                        | (data_pad[NUM_PINS-1:0] & mask_pad[NUM_PINS-1:0]);
    end

endmodule

// File: rtl/pin_event_irq.sv
// Top of the GPIO interrupt event detector.
// Detects per-pin events, holds them in write-1-to-clear status, qualifies
// them with an enable bitmap and registers one summary interrupt.
// Assumes pin_level is already synchronized to clk.
module pin_event_irq #(
    parameter int NUM_PINS  = 95,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
    parameter int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] level_sel,
    input  logic [NUM_PINS-1:0] invert,
    input  logic [NUM_PINS-1:0] sense_off,
    input  logic [NUM_PINS-1:0] owned,
    input  logic [NUM_PINS-1:0] gpio_mode,
    input  logic                wr_en,
    input  logic                wr_target,
    input  logic [WIDX_W-1:0]   wr_word,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [WIDX_W-1:0]   rd_word,
    output logic [WORD_W-1:0]   rd_status,
    output logic [WORD_W-1:0]   rd_enable,
    output logic                irq_out
);
    localparam int PAD_W = NUM_WORDS * WORD_W;

    logic [NUM_PINS-1:0] event_vec;
    logic [NUM_PINS-1:0] status_vec;
    logic [NUM_PINS-1:0] enable_vec;
    logic [NUM_PINS-1:0] clr_vec;
    logic [PAD_W-1:0]    clr_pad;
    logic [PAD_W-1:0]    status_pad;
    logic [PAD_W-1:0]    enable_pad;

    pin_event_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk       (clk),
        .pin_level (pin_level),
        .level_sel (level_sel),
        .invert    (invert),
        .sense_off (sense_off),
        .owned     (owned),
        .gpio_mode (gpio_mode),
        .event_vec (event_vec)
    );

    // Turn a status write into a clear mask at the addressed word.
    always_comb begin
        clr_pad = '0;
        if (wr_en && !wr_target)
            clr_pad = PAD_W'(wr_data) << (wr_word * WORD_W);
        clr_vec = clr_pad[NUM_PINS-1:0];
    end

    pin_status_bank #(.NUM_PINS(NUM_PINS)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_vec  (event_vec),
        .clr_vec    (clr_vec),
        .status_vec (status_vec)
    );

    pin_enable_bank #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W),
        .WIDX_W   (WIDX_W)
    ) i_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en && wr_target),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .enable_vec (enable_vec)
    );

    // Word readout; lanes without pins read as zero.
    always_comb begin
        status_pad = PAD_W'(status_vec);
        enable_pad = PAD_W'(enable_vec);
        rd_status  = WORD_W'(status_pad >> (rd_word * WORD_W));
        rd_enable  = WORD_W'(enable_pad >> (rd_word * WORD_W));
    end

    // Summary interrupt: any enabled pending pin, one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(status_vec & enable_vec);
    end

endmodule

// File: rtl/pin_event_irq_chk.sv
// Property checker for pin_event_irq, attached by bind below.
// Relates detector output, status bank, clear mask and summary interrupt.
module pin_event_irq_chk #(
    parameter int NUM_PINS = 95
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] event_vec,
    input logic [NUM_PINS-1:0] status_vec,
    input logic [NUM_PINS-1:0] enable_vec,
    input logic [NUM_PINS-1:0] clr_vec,
    input logic [NUM_PINS-1:0] sense_off,
    input logic [NUM_PINS-1:0] owned,
    input logic [NUM_PINS-1:0] gpio_mode,
    input logic                irq_out
);

    // R6: every event of the previous edge is held in status.
    p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_vec & $past(event_vec)) == $past(event_vec)));

    // R1: a status bit only rises where an event was flagged.
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_vec & ~$past(status_vec) & ~$past(event_vec)) == '0));

    // R5: a clear without a competing event leaves the bit at 0.
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_vec & $past(clr_vec & ~event_vec)) == '0));

    // R7: gated pins flag no events.
    p_gated_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_vec & (sense_off | ~owned | ~gpio_mode)) == '0);

    // R9: summary follows enabled status by one clock.
    p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_out == $past(|(status_vec & enable_vec))));

    // R10: reset empties status and drops the interrupt.
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (status_vec == '0 && enable_vec == '0 && !irq_out));

endmodule

bind pin_event_irq pin_event_irq_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_vec  (event_vec),
    .status_vec (status_vec),
    .enable_vec (enable_vec),
    .clr_vec    (clr_vec),
    .sense_off  (sense_off),
    .owned      (owned),
    .gpio_mode  (gpio_mode),
    .irq_out    (irq_out)
);

// File: tb/test_pin_event_irq.sv
// Sweeps every pin of a 40-pin configuration through all trigger kinds,
// level pairs and gating cases, plus reset, enable and clear tests.
module test_pin_event_irq;
    localparam int N  = 40;
    localparam int W  = 32;
    localparam int NW = 2;
    localparam int WI = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_level = '0, level_sel = '0, invert = '0;
    logic [N-1:0]  sense_off = '0, owned = '1, gpio_mode = '1;
    logic          wr_en = 1'b0, wr_target = 1'b0;
    logic [WI-1:0] wr_word = '0, rd_word = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_status, rd_enable;
    logic          irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_event_irq #(.NUM_PINS(N), .WORD_W(W)) i_pin_event_irq (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .level_sel(level_sel),
        .invert(invert), .sense_off(sense_off), .owned(owned), .gpio_mode(gpio_mode),
        .wr_en(wr_en), .wr_target(wr_target), .wr_word(wr_word), .wr_data(wr_data),
        .rd_word(rd_word), .rd_status(rd_status), .rd_enable(rd_enable), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit en_bit(input int p);
        return (p % 3) != 1;
    endfunction

    // One bus write, strobe held for one clock.
    task automatic bus_wr(input bit tgt, input int w, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_target = tgt; wr_word = WI'(w); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_word(input int w);
        rd_word = WI'(w);
        #1;
    endtask

    // One scenario: pin p, trigger kind k, gating g, level a then b.
    task automatic scenario(input int p, input int k, input int g, input bit a, input bit b);
        bit act_a, act_b, exp_bit;
        string tag;
        @(negedge clk);
        pin_level = '0;  pin_level[p] = a;
        level_sel = '0;  level_sel[p] = k[1];
        invert    = '0;  invert[p]    = k[0];
        sense_off = '1;  sense_off[p] = (g == 1);
        owned     = '1;  owned[p]     = (g != 2);
        gpio_mode = '1;  gpio_mode[p] = (g != 3);
        @(negedge clk);
        for (int w = 0; w < NW; w++) begin
            wr_en = 1'b1; wr_target = 1'b0; wr_word = WI'(w); wr_data = '1;
            @(negedge clk);
        end
        wr_en = 1'b0;
        pin_level[p] = b;
        @(negedge clk);
        act_a = (k == 2) ? !a : a;
        act_b = (k == 2) ? !b : b;
        case (k)
            0: exp_bit = !a && b;
            1: exp_bit = a && !b;
            default: exp_bit = act_a || act_b;
        endcase
        if (g != 0) exp_bit = 1'b0;
        case (k)
            0: tag = "R1 rising";
            1: tag = "R2 falling";
            2: tag = "R3 low level";
            default: tag = "R4 high level";
        endcase
        if (g != 0) tag = {tag, " R7 gated"};
        else if (k >= 2 && act_a && !act_b) tag = {tag, " R6 event beats clear"};
        read_word(p / W);
        chk($sformatf("%s pin %0d a=%0d b=%0d status", tag, p, a, b),
            rd_status, W'(exp_bit) << (p % W));
        @(negedge clk);
        chk($sformatf("R9 irq pin %0d kind %0d g %0d", p, k, g),
            W'(irq_out), W'(exp_bit && en_bit(p)));
    endtask

    initial begin
        logic [N-1:0] en_vec;
        // R10: levels high and rising triggers armed through reset.
        pin_level = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int w = 0; w < NW; w++) begin
            read_word(w);
            chk("R10 status after reset", rd_status, '0);
            chk("R10 enable after reset", rd_enable, '0);
        end
        chk("R10 irq after reset", W'(irq_out), '0);

        // R5: partial write-1-to-clear on pins 3 and 5.
        @(negedge clk);
        pin_level = '0; sense_off = '1; sense_off[3] = 1'b0; sense_off[5] = 1'b0;
        @(negedge clk);
        pin_level[3] = 1'b1; pin_level[5] = 1'b1;
        @(negedge clk);
        read_word(0);
        chk("R1 two rising edges", rd_status, 32'h28);
        bus_wr(1'b0, 0, 32'h08);
        read_word(0);
        chk("R5 clear only bit 3", rd_status, 32'h20);
        bus_wr(1'b0, 0, 32'h0);
        read_word(0);
        chk("R5 zero write keeps bit 5", rd_status, 32'h20);
        chk("R9 no irq with enables off", W'(irq_out), '0);

        // R8: enable readout and lane masking, then the sweep pattern.
        bus_wr(1'b1, 1, 32'hFFFF_FFFF);
        read_word(1);
        chk("R8 enable word 1 masked to pins", rd_enable, 32'h0000_00FF);
        en_vec = '0;
        for (int p = 0; p < N; p++) en_vec[p] = en_bit(p);
        bus_wr(1'b1, 0, en_vec[31:0]);
        bus_wr(1'b1, 1, W'(en_vec[N-1:32]));
        for (int w = 0; w < NW; w++) begin
            read_word(w);
            chk("R8 enable readback", rd_enable, W'(en_vec >> (w * W)));
        end
        // Pin 5 pending and now enabled.
        chk("R9 irq with pending enabled pin", W'(irq_out), 32'h1);
        bus_wr(1'b0, 0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R9 irq drops after clear", W'(irq_out), '0);

        // Full sweep.
        for (int p = 0; p < N; p++)
            for (int k = 0; k < 4; k++)
                for (int g = 0; g < 4; g++)
                    for (int ab = 0; ab < 4; ab++)
                        scenario(p, k, g, ab[1], ab[0]);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule